// File: doc/BRIEF.md
# Display Controller Interrupt Status Unit

This unit gathers single-cycle event pulses from the display pipeline and stores each one as a sticky status bit. There are eight sources: end of frame for buffer 1 and for buffer 0, palette loaded, FIFO underflow, AC-bias count reached, sync lost, raster frame done, and a shared frame-done bit. A mode input picks which engine drives the shared bit: the raster engine or the parallel-bus engine. Software works with the unit through a small register bus that has four word addresses. One address shows the raw status and lets software force bits for self-test. One shows the status filtered by the enables and clears bits written with ones. The last two set and clear enable bits, so no read-modify-write is ever needed.

A single registered interrupt line is high whenever at least one enabled status bit is set. Reads are combinational: the read data follows the address on the same cycle. Writes, hardware events and the interrupt line all take effect on the next rising clock edge.

Top module: `irq_status_ctrl`

## Requirements
- R1: Each source has a fixed bit position: 9 end-of-frame 1, 8 end-of-frame 0, 6 palette loaded, 5 FIFO underflow, 3 AC-bias count, 2 sync lost, 1 raster done, 0 shared frame done. A source that is high at a rising edge sets its status bit at that edge, and the bit stays set after the pulse ends.
- R2: Writing at address 0 sets every status bit whose write-data bit is 1; zero bits change nothing. Reading address 0 returns the full status whatever the enables are.
- R3: Reading address 1 returns status AND enables. Writing at address 1 clears every status bit whose write-data bit is 1, whether or not that bit is enabled; zero bits change nothing.
- R4: A write of ones at address 2 sets those enable bits; a write of ones at address 3 clears them; zero bits at either address change nothing. Reading address 2 or 3 returns the enable bits.
- R5: When `par_mode` is 0, status bit 0 is set by `ev_rast_frame` and `ev_par_frame` is ignored. When `par_mode` is 1, the roles swap.
- R6: If a source pulse and a clear write for the same bit arrive on the same edge, the bit ends up set. Other bits cleared by that write are still cleared.
- R7: `irq` is a register. After any edge that leaves at least one bit both set and enabled it is 1; otherwise it is 0. This includes the edge of the write or event that causes the change.
- R8: Bit positions 4, 7 and 10 upward always read as zero at every address and ignore writes.
- R9: While `rst_n` is low, all status bits, enable bits and `irq` are zero. The internal reset is released on the second rising edge after `rst_n` goes high, so events seen before that edge are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_eof1 | input | 1 | End-of-frame pulse, buffer 1 |
| ev_eof0 | input | 1 | End-of-frame pulse, buffer 0 |
| ev_pal | input | 1 | Palette loaded pulse |
| ev_uflow | input | 1 | FIFO underflow pulse |
| ev_acb | input | 1 | AC-bias count pulse |
| ev_sync_lost | input | 1 | Frame sync lost pulse |
| ev_rast_done | input | 1 | Raster frame done pulse (bit 1) |
| ev_rast_frame | input | 1 | Raster engine frame done, shared bit source |
| ev_par_frame | input | 1 | Parallel-bus engine frame done, shared bit source |
| par_mode | input | 1 | Shared bit source select, 1 = parallel bus |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| irq | output | 1 | Interrupt request |

## Verification
Read data is combinational, so the bench drives `bus_addr` and samples `bus_rdata` a short delay later within the same low clock phase. A write or an event pulse is driven at a falling edge and withdrawn at the next falling edge. Its effect on the status, the enables and `irq` is therefore due at exactly that second falling edge, after one rising edge. The bench samples all results there, with no extra waiting that could hide a cycle of extra latency. The reset check drives an event during the first rising edge after `rst_n` rises, inside the two-edge synchronizer window, and expects it to be dropped.

// File: rtl/irq_stat_pkg.sv
`timescale 1ns/1ps
package irq_stat_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_RAW = 2'd0,
    SEL_MSK = 2'd1,
    SEL_ENS = 2'd2,
    SEL_ENC = 2'd3
  } reg_sel_e;

  localparam int BIT_EOF1  = 9;
  localparam int BIT_EOF0  = 8;
  localparam int BIT_PAL   = 6;
  localparam int BIT_UFLOW = 5;
  localparam int BIT_ACB   = 3;
  localparam int BIT_SYNC  = 2;
  localparam int BIT_RAST  = 1;
  localparam int BIT_FRAME = 0;
  localparam int MIN_W     = BIT_EOF1 + 1;

  localparam logic [63:0] IMPL_MASK64 =
      (64'd1 << BIT_EOF1) | (64'd1 << BIT_EOF0) | (64'd1 << BIT_PAL) |
      (64'd1 << BIT_UFLOW) | (64'd1 << BIT_ACB) | (64'd1 << BIT_SYNC) |
      (64'd1 << BIT_RAST) | (64'd1 << BIT_FRAME);
endpackage

// File: rtl/irq_rst_sync.sv
`timescale 1ns/1ps
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/irq_evt_map.sv
`timescale 1ns/1ps
module irq_evt_map
  import irq_stat_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              ev_eof1,
  input  logic              ev_eof0,
  input  logic              ev_pal,
  input  logic              ev_uflow,
  input  logic              ev_acb,
  input  logic              ev_sync_lost,
  input  logic              ev_rast_done,
  input  logic              ev_rast_frame,
  input  logic              ev_par_frame,
  input  logic              par_mode,
  output logic [DATA_W-1:0] hw_vec
);
  logic frame_src;

  always_comb begin
    frame_src = par_mode ? ev_par_frame : ev_rast_frame;
    hw_vec            = '0;
    hw_vec[BIT_EOF1]  = ev_eof1;
    hw_vec[BIT_EOF0]  = ev_eof0;
    hw_vec[BIT_PAL]   = ev_pal;
    hw_vec[BIT_UFLOW] = ev_uflow;
    hw_vec[BIT_ACB]   = ev_acb;
    hw_vec[BIT_SYNC]  = ev_sync_lost;
    hw_vec[BIT_RAST]  = ev_rast_done;
    hw_vec[BIT_FRAME] = frame_src;
  end
endmodule

// File: rtl/irq_reg_if.sv
`timescale 1ns/1ps
module irq_reg_if
  import irq_stat_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] st_q,
  input  logic [DATA_W-1:0] en_q,
  output logic [DATA_W-1:0] sw_set,
  output logic [DATA_W-1:0] st_clr,
  output logic [DATA_W-1:0] en_set,
  output logic [DATA_W-1:0] en_clr,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam logic [DATA_W-1:0] IMPL = IMPL_MASK64[DATA_W-1:0];

  reg_sel_e          sel;
  logic [DATA_W-1:0] wmask;

  always_comb begin
    sel   = reg_sel_e'(bus_addr);
    wmask = bus_wdata & IMPL;
    sw_set = (bus_wr && sel == SEL_RAW) ? wmask : '0;
    st_clr = (bus_wr && sel == SEL_MSK) ? wmask : '0;
    en_set = (bus_wr && sel == SEL_ENS) ? wmask : '0;
    en_clr = (bus_wr && sel == SEL_ENC) ? wmask : '0;
  end

  always_comb begin
    unique case (sel)
      SEL_RAW: bus_rdata = st_q;
      SEL_MSK: bus_rdata = st_q & en_q;
      default: bus_rdata = en_q;
    endcase
  end
endmodule

// File: rtl/irq_bit_cell.sv
`timescale 1ns/1ps
module irq_bit_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic sw_set,
  input  logic st_clr,
  input  logic en_set,
  input  logic en_clr,
  output logic st_q,
  output logic en_q,
  output logic pend_nxt
);
  logic st_d, en_d, st_ce, en_ce;

  always_comb begin
    st_ce    = hw_set | sw_set | st_clr;
    st_d     = hw_set | sw_set | (st_q & ~st_clr);
    en_ce    = en_set | en_clr;
    en_d     = en_set | (en_q & ~en_clr);
    pend_nxt = (st_ce ? st_d : st_q) & (en_ce ? en_d : en_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= 1'b0;
    else if (st_ce) st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= 1'b0;
    else if (en_ce) en_q <= en_d;
  end
endmodule

// File: rtl/irq_status_ctrl.sv
`timescale 1ns/1ps
module irq_status_ctrl
  import irq_stat_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int SYNC_STGS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_eof1,
  input  logic              ev_eof0,
  input  logic              ev_pal,
  input  logic              ev_uflow,
  input  logic              ev_acb,
  input  logic              ev_sync_lost,
  input  logic              ev_rast_done,
  input  logic              ev_rast_frame,
  input  logic              ev_par_frame,
  input  logic              par_mode,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic              rst_n_s;
  logic [DATA_W-1:0] hw_vec, sw_set, st_clr, en_set, en_clr;
  logic [DATA_W-1:0] st_q, en_q, pend_nxt;
  logic              irq_d, irq_q;

  irq_rst_sync #(.STAGES(SYNC_STGS)) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  irq_evt_map #(.DATA_W(DATA_W)) u_evt_map (
    .ev_eof1       (ev_eof1),
    .ev_eof0       (ev_eof0),
    .ev_pal        (ev_pal),
    .ev_uflow      (ev_uflow),
    .ev_acb        (ev_acb),
    .ev_sync_lost  (ev_sync_lost),
    .ev_rast_done  (ev_rast_done),
    .ev_rast_frame (ev_rast_frame),
    .ev_par_frame  (ev_par_frame),
    .par_mode      (par_mode),
    .hw_vec        (hw_vec)
  );

  irq_reg_if #(.DATA_W(DATA_W)) u_reg_if (
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .st_q      (st_q),
    .en_q      (en_q),
    .sw_set    (sw_set),
    .st_clr    (st_clr),
    .en_set    (en_set),
    .en_clr    (en_clr),
    .bus_rdata (bus_rdata)
  );

  for (genvar b = 0; b < DATA_W; b++) begin : g_cell
    irq_bit_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .hw_set   (hw_vec[b]),
      .sw_set   (sw_set[b]),
      .st_clr   (st_clr[b]),
      .en_set   (en_set[b]),
      .en_clr   (en_clr[b]),
      .st_q     (st_q[b]),
      .en_q     (en_q[b]),
      .pend_nxt (pend_nxt[b])
    );
  end

  always_comb begin
    irq_d = |pend_nxt;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) irq_q <= 1'b0;
    else          irq_q <= irq_d;
  end

  assign irq = irq_q;
endmodule

// File: rtl/irq_status_chk.sv
`timescale 1ns/1ps
module irq_status_chk
  import irq_stat_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic [DATA_W-1:0] hw_vec,
  input logic [DATA_W-1:0] sw_set,
  input logic [DATA_W-1:0] st_clr,
  input logic [DATA_W-1:0] en_set,
  input logic [DATA_W-1:0] en_clr,
  input logic [DATA_W-1:0] st_q,
  input logic [DATA_W-1:0] en_q,
  input logic [1:0]        bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq
);
  localparam logic [DATA_W-1:0] IMPL = IMPL_MASK64[DATA_W-1:0];

  logic armed;
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) armed <= 1'b0;
    else          armed <= 1'b1;
  end

  // R1 and R6: a sampled source always leaves its bit set
  a_r1_event_sets: assert property (@(posedge clk) disable iff (!rst_n_s || !armed)
    (($past(hw_vec) & ~st_q) == '0));

  // R1: status is sticky unless a clear write hit it
  a_r1_sticky: assert property (@(posedge clk) disable iff (!rst_n_s || !armed)
    (($past(st_q) & ~$past(st_clr) & ~st_q) == '0));

  // R2: software set lands on the next edge
  a_r2_sw_set: assert property (@(posedge clk) disable iff (!rst_n_s || !armed)
    (($past(sw_set) & ~st_q) == '0));

  // R3: masked view on address 1
  a_r3_masked_read: assert property (@(posedge clk) disable iff (!rst_n_s || !armed)
    (bus_addr == 2'd1) |-> (bus_rdata == (st_q & en_q)));

  // R4: enable register moves only by set and clear writes
  a_r4_enable_update: assert property (@(posedge clk) disable iff (!rst_n_s || !armed)
    en_q == (($past(en_q) & ~$past(en_clr)) | $past(en_set)));

  // R7: interrupt line agrees with the stored state
  a_r7_irq_match: assert property (@(posedge clk) disable iff (!rst_n_s || !armed)
    irq == |(st_q & en_q));

  // R8: unimplemented positions read zero
  a_r8_unused_zero: assert property (@(posedge clk) disable iff (!rst_n_s || !armed)
    ((bus_rdata & ~IMPL) == '0));
endmodule

bind irq_status_ctrl irq_status_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n_s   (rst_n_s),
  .hw_vec    (hw_vec),
  .sw_set    (sw_set),
  .st_clr    (st_clr),
  .en_set    (en_set),
  .en_clr    (en_clr),
  .st_q      (st_q),
  .en_q      (en_q),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq       (irq)
);

// File: tb/test_irq_status_ctrl.sv
`timescale 1ns/1ps
module test_irq_status_ctrl;
  localparam int W = 16;
  localparam logic [W-1:0] ALL = 16'h036F;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [8:0]   ev;
  logic         par_mode;
  logic         bus_wr;
  logic [1:0]   bus_addr;
  logic [W-1:0] bus_wdata;
  logic [W-1:0] bus_rdata;
  logic         irq;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  irq_status_ctrl #(.DATA_W(W)) i_irq_status_ctrl (
    .clk (clk), .rst_n (rst_n),
    .ev_eof1 (ev[0]), .ev_eof0 (ev[1]), .ev_pal (ev[2]), .ev_uflow (ev[3]),
    .ev_acb (ev[4]), .ev_sync_lost (ev[5]), .ev_rast_done (ev[6]),
    .ev_rast_frame (ev[7]), .ev_par_frame (ev[8]), .par_mode (par_mode),
    .bus_wr (bus_wr), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata), .irq (irq)
  );

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic chk_rd(input string tag, input logic [1:0] a, input logic [W-1:0] exp);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk);
    ev[idx] = 1'b1;
    @(negedge clk);
    ev = '0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; ev = '0; par_mode = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    chk_rd("R9 raw in reset", 2'd0, '0);
    chk_rd("R9 enable in reset", 2'd2, '0);
    chk("R9 irq in reset", {15'd0, irq}, '0);
    rst_n = 1'b1; ev[2] = 1'b1;
    @(negedge clk);
    ev = '0;
    repeat (2) @(negedge clk);
    chk_rd("R9 event in sync window dropped", 2'd0, '0);
  endtask

  task automatic t_hw_events;
    logic [W-1:0] exp;
    logic [W-1:0] pos [9];
    pos = '{16'h200, 16'h100, 16'h040, 16'h020, 16'h008, 16'h004, 16'h002, 16'h001, 16'h000};
    exp = '0;
    for (int i = 0; i < 8; i++) begin
      pulse(i);
      exp |= pos[i];
      chk_rd("R1 event sets its bit", 2'd0, exp);
    end
    repeat (3) @(negedge clk);
    chk_rd("R1 sticky after pulses", 2'd0, ALL);
    chk("R7 irq low with no enables", {15'd0, irq}, '0);
    wr(2'd1, 16'h0000);
    chk_rd("R3 zero clear write no effect", 2'd0, ALL);
    wr(2'd1, 16'hFFFF);
    chk_rd("R3 clear ignores enables", 2'd0, '0);
  endtask

  task automatic t_sw_set;
    wr(2'd0, 16'hFFFF);
    chk_rd("R2 R8 raw set masks unused", 2'd0, ALL);
    wr(2'd0, 16'h0000);
    chk_rd("R2 zero write keeps status", 2'd0, ALL);
    chk_rd("R8 masked view unused zero", 2'd1, '0);
    wr(2'd1, ALL);
    chk_rd("R3 all cleared", 2'd0, '0);
  endtask

  task automatic t_enable;
    wr(2'd2, 16'h0101);
    chk_rd("R4 enable set read at 2", 2'd2, 16'h0101);
    chk_rd("R4 enable read at 3", 2'd3, 16'h0101);
    wr(2'd2, 16'h0000);
    chk_rd("R4 zero set no effect", 2'd2, 16'h0101);
    wr(2'd3, 16'h0000);
    chk_rd("R4 zero clear no effect", 2'd2, 16'h0101);
    wr(2'd3, 16'h0100);
    chk_rd("R4 clear one enable", 2'd2, 16'h0001);
    wr(2'd2, 16'hFFFF);
    chk_rd("R8 enable unused bits", 2'd2, ALL);
    wr(2'd3, 16'hFFFF);
    chk_rd("R4 clear all enables", 2'd3, '0);
  endtask

  task automatic t_masked_irq;
    wr(2'd2, 16'h0020);
    wr(2'd0, 16'h0044);
    chk_rd("R3 masked hides disabled", 2'd1, '0);
    chk("R7 irq low, nothing enabled pending", {15'd0, irq}, '0);
    pulse(3);
    chk_rd("R2 raw shows all", 2'd0, 16'h0064);
    chk_rd("R3 masked shows enabled", 2'd1, 16'h0020);
    chk("R7 irq on event edge", {15'd0, irq}, 16'd1);
    wr(2'd1, 16'h0020);
    chk("R7 irq drops on clear edge", {15'd0, irq}, '0);
    chk_rd("R3 clear leaves others", 2'd0, 16'h0044);
    wr(2'd2, 16'h0004);
    chk("R7 irq on enable set edge", {15'd0, irq}, 16'd1);
    wr(2'd3, 16'h0004);
    chk("R7 irq drops on enable clear edge", {15'd0, irq}, '0);
    wr(2'd1, ALL);
    wr(2'd3, ALL);
  endtask

  task automatic t_mode;
    par_mode = 1'b0;
    pulse(8);
    chk_rd("R5 parallel ignored in raster mode", 2'd0, '0);
    pulse(7);
    chk_rd("R5 raster sets bit0", 2'd0, 16'h0001);
    wr(2'd1, 16'h0001);
    par_mode = 1'b1;
    pulse(7);
    chk_rd("R5 raster ignored in parallel mode", 2'd0, '0);
    pulse(8);
    chk_rd("R5 parallel sets bit0", 2'd0, 16'h0001);
    wr(2'd1, 16'h0001);
    par_mode = 1'b0;
  endtask

  task automatic t_collide;
    wr(2'd0, 16'h0048);
    @(negedge clk);
    ev[2] = 1'b1; bus_addr = 2'd1; bus_wdata = 16'h0048; bus_wr = 1'b1;
    @(negedge clk);
    ev = '0; bus_wr = 1'b0; bus_wdata = '0;
    chk_rd("R6 event beats clear", 2'd0, 16'h0040);
    wr(2'd1, 16'h0040);
    chk_rd("R6 later clear works", 2'd0, '0);
  endtask

  initial begin
    t_reset();
    t_hw_events();
    t_sw_set();
    t_enable();
    t_masked_irq();
    t_mode();
    t_collide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule